// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block chooses the address of the next instruction for a small accumulator machine. The machine has 16-bit instruction words, 8-bit data and a 15-bit instruction address space. Each cycle the unit takes in the current program counter, the instruction word being executed, the zero and carry flags, and the return-address and index registers. One clock edge later it presents the next program counter, a strobe with the value to write into the return-address register, and a flag that marks a redirected (taken) transfer.

The unit recognises every control-flow form of the instruction set:

- a call that covers every word with a clear top bit;
- unconditional and zero-dependent relative branches with an 11-bit signed offset;
- plain returns, and the return that also loads the accumulator (only its address part is handled here);
- returns that depend on the carry or zero flag;
- a call and a jump that go through the index register.

Any other word, and any conditional form whose condition fails, advances the counter by one. Linking instructions save the address that follows the current one.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `next_pc`=0, `taken`=0, `ra_we`=0 and `ra_val`=0.
- R2: Outputs are registered. The values present after clock edge k are computed from the inputs sampled at edge k, and they do not change between edges.
- R3: A word with bit 15 equal to 0 is a call. `next_pc` = inst[14:0], `taken`=1, `ra_we`=1 and `ra_val` = pc+1 (mod 2^15).
- R4: A word matching 1011_0xxx_xxxx_xxxx branches always, to pc + sign-extended inst[10:0] (mod 2^15), with `taken`=1.
- R5: 1011_1xxx_xxxx_xxxx branches to the same relative target only when zero=1. 1010_1xxx_xxxx_xxxx branches only when zero=0.
- R6: 1000_1010_0xxx_xxxx and 1000_11xx_xxxx_xxxx both return: `next_pc` = ra and `taken`=1.
- R7: 1000_1011_0xxx_xxxx returns to ra only when carry=1. 1000_1011_1xxx_xxxx returns to ra only when zero=1.
- R8: 1000_1010_100x_xxxx gives `next_pc` = ix with a link (`ra_we`=1, `ra_val`=pc+1). 1000_1010_101x_xxxx gives `next_pc` = ix with no link.
- R9: Every other word, and any conditional form whose condition is false, gives `next_pc` = pc+1 (mod 2^15, so 0x7FFF wraps to 0) with `taken`=0.
- R10: `ra_we` is 1 only for the call of R3 and the indexed call of R8, and `taken` is 1 whenever `ra_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | 15 | Address of the current instruction |
| inst | input | 16 | Current instruction word |
| zf | input | 1 | Zero flag |
| cf | input | 1 | Carry flag |
| ra | input | 15 | Return-address register value |
| ix | input | 15 | Index register value |
| next_pc | output | 15 | Registered next program counter |
| taken | output | 1 | Registered: control transfer redirected the counter |
| ra_we | output | 1 | Registered: write strobe for the return-address register |
| ra_val | output | 15 | Registered: value to write into the return-address register |

## Verification
The assertions assume that every input is settled at each rising edge and takes a known value there. They compare outputs against the inputs of the previous edge only once one full cycle has passed since reset. The bench drives all inputs on the falling edge, so each value is stable well before the edge that samples it. Random words are drawn with a bias toward the control-flow prefixes, so that every form is reached with both flag values. The inputs ra, ix and pc range over the whole 15-bit space, which includes the wrap of the counter and of the relative target.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    parameter int unsigned ADDR_W = 15;
    parameter int unsigned INST_W = 16;
    parameter int unsigned REL_W  = 11;

    typedef enum logic [3:0] {
        K_SEQ, K_JAL, K_BR, K_BZ, K_BNZ, K_RET, K_RETI,
        K_RC, K_RZ, K_CALLX, K_JMPX
    } flow_e;

    typedef enum logic [2:0] {
        SRC_SEQ, SRC_ABS, SRC_REL, SRC_RA, SRC_IX
    } src_e;

    typedef struct packed {
        flow_e kind;
        src_e  src;
        logic  taken;
        logic  link;
    } flow_t;

    // Classify a 16-bit instruction word by its control-flow prefix.
    function automatic flow_e classify(input logic [15:0] w);
        flow_e k;
        k = K_SEQ;
        if (!w[15]) begin
            k = K_JAL;
        end else begin
            case (w[14:12])
                3'b011: k = w[11] ? K_BZ : K_BR;
                3'b010: k = w[11] ? K_BNZ : K_SEQ;
                3'b000: begin
                    if (w[11:10] == 2'b11) begin
                        k = K_RETI;
                    end else if (w[11:8] == 4'b1010) begin
                        if (!w[7])                k = K_RET;
                        else if (w[6:5] == 2'b00) k = K_CALLX;
                        else if (w[6:5] == 2'b01) k = K_JMPX;
                        else                      k = K_SEQ;
                    end else if (w[11:8] == 4'b1011) begin
                        k = w[7] ? K_RZ : K_RC;
                    end
                end
                default: k = K_SEQ;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
#(
    parameter int unsigned INST_W = pcu_pkg::INST_W
) (
    input  logic [INST_W-1:0] inst,
    input  logic              zf,
    input  logic              cf,
    output flow_t             flow
);
    flow_e kind;
    logic  cond_ok;

    always_comb begin
        kind = classify(inst[15:0]);
        case (kind)
            K_BZ, K_RZ: cond_ok = zf;
            K_BNZ:      cond_ok = !zf;
            K_RC:       cond_ok = cf;
            K_SEQ:      cond_ok = 1'b0;
            default:    cond_ok = 1'b1;
        endcase
    end

    always_comb begin
        flow.kind  = kind;
        flow.taken = cond_ok;
        flow.link  = (kind == K_JAL) || (kind == K_CALLX);
        if (!cond_ok) begin
            flow.src = SRC_SEQ;
        end else begin
            case (kind)
                K_JAL:                  flow.src = SRC_ABS;
                K_BR, K_BZ, K_BNZ:      flow.src = SRC_REL;
                K_RET, K_RETI, K_RC, K_RZ: flow.src = SRC_RA;
                K_CALLX, K_JMPX:        flow.src = SRC_IX;
                default:                flow.src = SRC_SEQ;
            endcase
        end
    end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = pcu_pkg::ADDR_W,
    parameter int unsigned INST_W = pcu_pkg::INST_W,
    parameter int unsigned REL_W  = pcu_pkg::REL_W
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [INST_W-1:0] inst,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] ix,
    input  src_e              src,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq_pc
);
    localparam int unsigned EXT_W = ADDR_W - REL_W;

    logic [ADDR_W-1:0] rel_off;
    logic [ADDR_W-1:0] rel_pc;

    generate
        if (EXT_W > 0) begin : g_sext
            assign rel_off = {{EXT_W{inst[REL_W-1]}}, inst[REL_W-1:0]};
        end else begin : g_trunc
            assign rel_off = inst[ADDR_W-1:0];
        end
    endgenerate

    assign seq_pc = pc + ADDR_W'(1);
    assign rel_pc = pc + rel_off;

    always_comb begin
        case (src)
            SRC_ABS: target = inst[ADDR_W-1:0];
            SRC_REL: target = rel_pc;
            SRC_RA:  target = ra;
            SRC_IX:  target = ix;
            default: target = seq_pc;
        endcase
    end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = pcu_pkg::ADDR_W,
    parameter int unsigned INST_W = pcu_pkg::INST_W,
    parameter int unsigned REL_W  = pcu_pkg::REL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc,
    input  logic [INST_W-1:0] inst,
    input  logic              zf,
    input  logic              cf,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] ix,
    output logic [ADDR_W-1:0] next_pc,
    output logic              taken,
    output logic              ra_we,
    output logic [ADDR_W-1:0] ra_val
);
    flow_t             flow;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] seq_pc;

    pcu_decode #(.INST_W(INST_W)) u_dec (
        .inst (inst),
        .zf   (zf),
        .cf   (cf),
        .flow (flow)
    );

    pcu_target #(.ADDR_W(ADDR_W), .INST_W(INST_W), .REL_W(REL_W)) u_tgt (
        .pc     (pc),
        .inst   (inst),
        .ra     (ra),
        .ix     (ix),
        .src    (flow.src),
        .target (target),
        .seq_pc (seq_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc <= '0;
            taken   <= 1'b0;
            ra_we   <= 1'b0;
            ra_val  <= '0;
        end else begin
            next_pc <= target;
            taken   <= flow.taken;
            ra_we   <= flow.link;
            ra_val  <= flow.link ? seq_pc : '0;
        end
    end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned INST_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pc,
    input logic [INST_W-1:0] inst,
    input logic              zf,
    input logic              cf,
    input logic [ADDR_W-1:0] ra,
    input logic [ADDR_W-1:0] ix,
    input logic [ADDR_W-1:0] next_pc,
    input logic              taken,
    input logic              ra_we,
    input logic [ADDR_W-1:0] ra_val
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: outputs cleared on the edge after reset is held
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!taken && !ra_we && next_pc == '0));

    // R3: call loads absolute target and links
    a_r3_call_links: assert property (@(posedge clk) disable iff (rst)
        (armed && !inst[15]) |=>
        (next_pc == $past(inst[ADDR_W-1:0]) && ra_we && taken &&
         ra_val == ADDR_W'($past(pc) + 1'b1)));

    // R7: carry return taken when carry set
    a_r7_carry_return: assert property (@(posedge clk) disable iff (rst)
        (armed && inst[15:7] == 9'b1000_1011_0 && cf) |=>
        (taken && next_pc == $past(ra)));

    // R5: branch-if-zero with zero clear falls through
    a_r5_bz_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (armed && inst[15:11] == 5'b10111 && !zf) |=>
        (!taken && next_pc == ADDR_W'($past(pc) + 1'b1)));

    // R9: any untaken result advances by one
    a_r9_seq_advance: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !taken) |->
        (next_pc == ADDR_W'($past(pc) + 1'b1)));

    // R10: a link strobe implies a taken transfer
    a_r10_link_taken: assert property (@(posedge clk) disable iff (rst)
        ra_we |-> taken);

    // R8: indexed jump never links
    a_r8_ix_jump: assert property (@(posedge clk) disable iff (rst)
        (armed && inst[15:5] == 11'b1000_1010_101) |=>
        (!ra_we && next_pc == $past(ix)));
endmodule

bind pcu_top pcu_checker #(.ADDR_W(ADDR_W), .INST_W(INST_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc),
    .inst    (inst),
    .zf      (zf),
    .cf      (cf),
    .ra      (ra),
    .ix      (ix),
    .next_pc (next_pc),
    .taken   (taken),
    .ra_we   (ra_we),
    .ra_val  (ra_val)
);

// File: tb/pcu_top_test.sv
module pcu_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] pc, ra, ix;
    logic [15:0] inst;
    logic        zf, cf;
    logic [14:0] next_pc, ra_val;
    logic        taken, ra_we;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pcu_top uut (
        .clk(clk), .rst(rst), .pc(pc), .inst(inst), .zf(zf), .cf(cf),
        .ra(ra), .ix(ix), .next_pc(next_pc), .taken(taken),
        .ra_we(ra_we), .ra_val(ra_val)
    );

    // Expected {taken, ra_we, ra_val, next_pc}
    function automatic logic [31:0] model(input logic [15:0] w, input logic [14:0] p,
                                          input logic z, input logic c,
                                          input logic [14:0] r, input logic [14:0] x);
        logic [14:0] p1, rel, nx, rv;
        logic t, l;
        p1 = p + 15'd1;
        rel = p + {{4{w[10]}}, w[10:0]};
        nx = p1; t = 0; l = 0; rv = 0;
        casez (w)
            16'b0???_????_????_????: begin nx = w[14:0]; t = 1; l = 1; rv = p1; end
            16'b1011_0???_????_????: begin nx = rel; t = 1; end
            16'b1011_1???_????_????: if (z)  begin nx = rel; t = 1; end
            16'b1010_1???_????_????: if (!z) begin nx = rel; t = 1; end
            16'b1000_11??_????_????: begin nx = r; t = 1; end
            16'b1000_1010_0???_????: begin nx = r; t = 1; end
            16'b1000_1010_100?_????: begin nx = x; t = 1; l = 1; rv = p1; end
            16'b1000_1010_101?_????: begin nx = x; t = 1; end
            16'b1000_1011_0???_????: if (c) begin nx = r; t = 1; end
            16'b1000_1011_1???_????: if (z) begin nx = r; t = 1; end
            default: ;
        endcase
        return {t, l, rv, nx};
    endfunction

    function automatic string tag(input logic [15:0] w);
        casez (w)
            16'b0???_????_????_????: return "R3";
            16'b1011_0???_????_????: return "R4";
            16'b1011_1???_????_????, 16'b1010_1???_????_????: return "R5";
            16'b1000_11??_????_????, 16'b1000_1010_0???_????: return "R6";
            16'b1000_1011_????_????: return "R7";
            16'b1000_1010_10??_????: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string req, input logic [31:0] exp);
        logic [31:0] act;
        act = {taken, ra_we, ra_val, next_pc};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst=%h pc=%h actual=%h expected=%h", req, inst, pc, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w, input logic [14:0] p, input logic z,
                         input logic c, input logic [14:0] r, input logic [14:0] x,
                         input string req);
        logic [31:0] exp;
        @(negedge clk);
        inst = w; pc = p; zf = z; cf = c; ra = r; ix = x;
        exp = model(w, p, z, c, r, x);
        @(posedge clk); #1;
        compare(req, exp);
        // R10: link strobe only with a taken transfer
        checks++;
        if (ra_we && !taken) begin
            fails++;
            $display("FAIL R10 ra_we=%b taken=%b expected taken=1", ra_we, taken);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1234));
        rst = 1; pc = 15'h0123; inst = 16'h0456; zf = 0; cf = 0; ra = 0; ix = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 32'd0);
        @(negedge clk); rst = 0;

        apply(16'h1234, 15'h0010, 0, 0, 15'h1, 15'h2, "R3");
        apply(16'h7FFF, 15'h7FFF, 0, 0, 15'h1, 15'h2, "R3");
        apply(16'hB7FC, 15'h0002, 0, 0, 15'h1, 15'h2, "R4");
        apply(16'hB3FF, 15'h0100, 0, 0, 15'h1, 15'h2, "R4");
        apply(16'hB805, 15'h0200, 1, 0, 15'h1, 15'h2, "R5");
        apply(16'hB805, 15'h0200, 0, 0, 15'h1, 15'h2, "R5");
        apply(16'hAC00, 15'h0300, 0, 0, 15'h1, 15'h2, "R5");
        apply(16'hAC00, 15'h0300, 1, 0, 15'h1, 15'h2, "R5");
        apply(16'h8A12, 15'h0040, 0, 0, 15'h5A5A, 15'h2, "R6");
        apply(16'h8CFF, 15'h0040, 0, 0, 15'h3333, 15'h2, "R6");
        apply(16'h8B00, 15'h0050, 0, 1, 15'h4444, 15'h2, "R7");
        apply(16'h8B00, 15'h0050, 1, 0, 15'h4444, 15'h2, "R7");
        apply(16'h8B80, 15'h0050, 1, 0, 15'h4444, 15'h2, "R7");
        apply(16'h8B80, 15'h0050, 0, 1, 15'h4444, 15'h2, "R7");
        apply(16'h8A80, 15'h0060, 0, 0, 15'h1, 15'h6666, "R8");
        apply(16'h8AA0, 15'h0060, 0, 0, 15'h1, 15'h6666, "R8");
        apply(16'h8AC0, 15'h0060, 1, 1, 15'h1, 15'h6666, "R9");
        apply(16'hA200, 15'h7FFF, 1, 1, 15'h1, 15'h2, "R9");
        apply(16'hF400, 15'h0070, 1, 1, 15'h1, 15'h2, "R9");

        // R2: new inputs do not reach the outputs before the next edge
        held = model(16'hF400, 15'h0070, 1, 1, 15'h1, 15'h2);
        @(negedge clk);
        inst = 16'h0ABC; pc = 15'h1111;
        #1;
        compare("R2", held);
        @(posedge clk); #1;
        compare("R2", model(16'h0ABC, 15'h1111, 1, 1, 15'h1, 15'h2));

        for (int i = 0; i < 400; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            case ($urandom % 8)
                0: w[15:11] = 5'b10110;
                1: w[15:11] = 5'b10111;
                2: w[15:11] = 5'b10101;
                3: w[15:8]  = 8'b1000_1010;
                4: w[15:8]  = 8'b1000_1011;
                5: w[15:10] = 6'b1000_11;
                default: ;
            endcase
            apply(w, 15'($urandom), 1'($urandom), 1'($urandom),
                  15'($urandom), 15'($urandom), tag(w));
        end

        // R1: reset asserted mid-run clears outputs
        @(negedge clk); rst = 1; inst = 16'h0001;
        @(posedge clk); #1;
        compare("R1", 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule